// File: doc/BRIEF.md
# Trimmed Real-Time Clock Counter

This block keeps wall-clock seconds. A one-cycle crystal strobe (32.768 kHz nominal, presented as a clock enable in the system clock domain) is divided down to a nominal 1 Hz output tick. A programmable divisor sets the base period. A fine trim makes a chosen number of periods in every group of 1023 one strobe longer, so the average rate can be set to a fraction of a strobe. Each output tick advances a 32-bit seconds counter. The counter is compared against an alarm value.

Software reaches the block through a small word-addressed register bus with combinational reads and single-cycle writes. It programs the alarm, the seconds value and the trim. It reads and clears two event flags, one for alarm match and one for each tick. Each flag has its own enable, and each enable gates one interrupt line.

Top module: `rtc_trim_top`

## Requirements
- R1: After reset the alarm and seconds registers read 0, the trim register reads 0x00007FFF (divisor field 0x7FFF, trim field 0), and the status register and both interrupt outputs read 0.
- R2: With no trim active, output ticks are C+1 strobes apart. C is trim-register bits 15:0. Cycles with the strobe low do not advance the divider.
- R3: Periods are numbered within a repeating group of 1023, starting at 0. A period whose number is below D is one strobe longer, where D is trim-register bits 25:16. D = 1023 lengthens every period, and the numbering wraps from 1022 back to 0.
- R4: The seconds register advances by one on every output tick and wraps from 0xFFFFFFFF to 0.
- R5: A write to the seconds register (offset 0x04) takes effect on the next clock. It restarts both the divider phase and the group numbering. It overrides an advance in the same cycle.
- R6: A new trim value (offset 0x08) is adopted at the end of the current output period and does not alter that period.
- R7: The alarm flag (status bit 0) sets on the tick that makes the seconds value equal the alarm register (offset 0x00).
- R8: The tick flag (status bit 1) sets on every output tick.
- R9: Writing the status register (offset 0x10) with bit 0 or bit 1 at 1 clears that flag, and a 0 there leaves it unchanged. If a flag is set and cleared in the same cycle, the flag ends up set.
- R10: Status bit 2 enables the alarm interrupt and bit 3 enables the tick interrupt. Each interrupt output is high exactly while its flag and its enable are both 1.
- R11: A read of an unmapped offset returns 0, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_en | input | 1 | One-cycle crystal strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_tick | output | 1 | Tick interrupt |

## Verification
The case that needs care is a status write that clears a flag landing on the same clock edge as an output tick that sets it. The same applies to a seconds write landing on the edge where the counter would advance. The bench holds the strobe high, so the period in cycles is known. It finds a counter change, counts forward the exact number of cycles, and issues the write so that it lands on the next tick edge. It then checks that both flags still read 1 and that the seconds register holds the written value and not the advanced one.

// File: rtl/rtc_pkg.sv
// Package: register offsets, status bit positions and the address decoder
// shared by the trimmed real-time clock blocks.
package rtc_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_ALARM = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_TRIM  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h10;

    // Flag index inside the status flag vector; enables sit two bits higher.
    localparam int FLG_ALARM = 0;
    localparam int FLG_TICK  = 1;
    localparam int NFLAG     = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ALARM,
        SEL_COUNT,
        SEL_TRIM,
        SEL_STAT
    } reg_sel_e;

    // Map a byte offset to a register selector.
    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_ALARM: return SEL_ALARM;
            OFS_COUNT: return SEL_COUNT;
            OFS_TRIM:  return SEL_TRIM;
            OFS_STAT:  return SEL_STAT;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rtc_trim_div.sv
// Trimmed divider: counts crystal strobes and emits a one-cycle tick every
// C+1 strobes. Periods whose number within a 1023-period group is below D
// take one extra strobe. New C/D are adopted at each tick. Assumes xtal_en
// is a single-cycle strobe synchronous to clk.
module rtc_trim_div #(
    parameter int          DIV_W   = 16,
    parameter int          DEL_W   = 10,
    parameter int          GROUP   = 1023,
    parameter logic [15:0] RESET_C = 16'h7FFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_en,
    input  logic             restart,
    input  logic [DIV_W-1:0] trim_c,
    input  logic [DEL_W-1:0] trim_d,
    output logic             tick
);

    localparam int GRP_W = $clog2(GROUP);

    logic [DIV_W:0]   phase;
    logic [DIV_W:0]   limit;
    logic [DIV_W-1:0] cur_c;
    logic [DEL_W-1:0] cur_d;
    logic [GRP_W-1:0] grp_idx;
    logic             long_per;
    logic             grp_last;

    // Decide whether the running period carries the extra strobe.
    always_comb begin
        long_per = 32'(grp_idx) < 32'(cur_d);
        limit    = {1'b0, cur_c} + (DIV_W+1)'(long_per);
        grp_last = grp_idx == GRP_W'(GROUP - 1);
    end

    // Advance the phase on strobes, emit the tick and adopt the new trim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            grp_idx <= '0;
            cur_c   <= DIV_W'(RESET_C);
            cur_d   <= '0;
            tick    <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (restart) begin
                phase   <= '0;
                grp_idx <= '0;
            end else if (xtal_en) begin
                if (phase == limit) begin
                    phase   <= '0;
                    tick    <= 1'b1;
                    grp_idx <= grp_last ? '0 : grp_idx + 1'b1;
                    cur_c   <= trim_c;
                    cur_d   <= trim_d;
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rtc_sec_count.sv
// Seconds counter: loads on a write, otherwise advances on each tick and
// reports a match when the advanced value equals the alarm value.
module rtc_sec_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] alarm_val,
    output logic [CNT_W-1:0] count,
    output logic             alarm_hit
);

    logic [CNT_W-1:0] count_nxt;

    // Next value and alarm match for an advancing tick.
    always_comb begin
        count_nxt = count + CNT_W'(1);
        alarm_hit = tick && !load && (count_nxt == alarm_val);
    end

    // Hold the seconds value; a load wins over an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= count_nxt;
        end
    end

endmodule

// File: rtl/rtc_status_flags.sv
// Event flags with write-one-to-clear, per-flag enables and gated interrupt
// outputs. A set and a clear in the same cycle leave the flag set.
module rtc_status_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          wr_i,
    input  logic [NF-1:0] clr_i,
    input  logic [NF-1:0] en_i,
    output logic [NF-1:0] flag_o,
    output logic [NF-1:0] en_o,
    output logic [NF-1:0] irq_o
);

    for (genvar g = 0; g < NF; g++) begin : g_flag
        // One flag and its enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_o[g] <= 1'b0;
                en_o[g]   <= 1'b0;
            end else begin
                flag_o[g] <= set_i[g] | (flag_o[g] & ~(wr_i & clr_i[g]));
                if (wr_i) begin
                    en_o[g] <= en_i[g];
                end
            end
        end
        assign irq_o[g] = flag_o[g] & en_o[g];
    end

endmodule

// File: rtl/rtc_trim_top.sv
// Top of the trimmed real-time clock: register decode, alarm and trim
// storage, and wiring of divider, seconds counter and status flags.
// Assumes a single clock domain and one-cycle bus writes.
module rtc_trim_top
    import rtc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int DIV_W  = 16,
    parameter int DEL_W  = 10,
    parameter int GROUP  = 1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_alarm,
    output logic              irq_tick
);

    localparam int TRIM_W = DIV_W + DEL_W;

    reg_sel_e         sel;
    logic             cnt_wr;
    logic             st_wr;
    logic             trim_wr;
    logic             alarm_wr;
    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] count_q;
    logic [DIV_W-1:0] trim_c_q;
    logic [DEL_W-1:0] trim_d_q;
    logic             div_tick;
    logic             alarm_hit;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] en_q;
    logic [NFLAG-1:0] irq_v;
    logic [NFLAG-1:0] set_v;

    // Decode the offset into per-register write strobes.
    always_comb begin
        sel      = decode_ofs(bus_addr);
        alarm_wr = bus_we && (sel == SEL_ALARM);
        cnt_wr   = bus_we && (sel == SEL_COUNT);
        trim_wr  = bus_we && (sel == SEL_TRIM);
        st_wr    = bus_we && (sel == SEL_STAT);
    end

    // Alarm and trim storage written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q  <= '0;
            trim_c_q <= DIV_W'(16'h7FFF);
            trim_d_q <= '0;
        end else begin
            if (alarm_wr) begin
                alarm_q <= bus_wdata[CNT_W-1:0];
            end
            if (trim_wr) begin
                trim_c_q <= bus_wdata[DIV_W-1:0];
                trim_d_q <= bus_wdata[TRIM_W-1:DIV_W];
            end
        end
    end

    rtc_trim_div #(
        .DIV_W   (DIV_W),
        .DEL_W   (DEL_W),
        .GROUP   (GROUP),
        .RESET_C (16'h7FFF)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .xtal_en (xtal_en),
        .restart (cnt_wr),
        .trim_c  (trim_c_q),
        .trim_d  (trim_d_q),
        .tick    (div_tick)
    );

    rtc_sec_count #(
        .CNT_W (CNT_W)
    ) u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (div_tick),
        .load      (cnt_wr),
        .load_val  (bus_wdata[CNT_W-1:0]),
        .alarm_val (alarm_q),
        .count     (count_q),
        .alarm_hit (alarm_hit)
    );

    // Order the set events to match the flag index.
    always_comb begin
        set_v            = '0;
        set_v[FLG_ALARM] = alarm_hit;
        set_v[FLG_TICK]  = div_tick;
    end

    rtc_status_flags #(
        .NF (NFLAG)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .wr_i   (st_wr),
        .clr_i  (bus_wdata[NFLAG-1:0]),
        .en_i   (bus_wdata[2*NFLAG-1:NFLAG]),
        .flag_o (flag_q),
        .en_o   (en_q),
        .irq_o  (irq_v)
    );

    assign irq_alarm = irq_v[FLG_ALARM];
    assign irq_tick  = irq_v[FLG_TICK];

    // Combinational read mux; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_ALARM: bus_rdata = DATA_W'(alarm_q);
            SEL_COUNT: bus_rdata = DATA_W'(count_q);
            SEL_TRIM:  bus_rdata = DATA_W'({trim_d_q, trim_c_q});
            SEL_STAT:  bus_rdata = DATA_W'({en_q, flag_q});
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_trim_chk.sv
// Checker for rtc_trim_top: temporal properties over the tick, the seconds
// value and the flags. Attached by the bind at the end of this file.
module rtc_trim_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xtal_en,
    input logic              tick,
    input logic              cnt_wr,
    input logic              st_wr,
    input logic [DATA_W-1:0] wdata,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  alarm,
    input logic [1:0]        flags
);

    // R2: a tick only follows a strobe
    a_r2_tick_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(xtal_en));

    // R4: a tick without a write advances the seconds by one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (count == $past(count) + CNT_W'(1)));

    // R5: a seconds write lands on the next clock
    a_r5_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wdata[CNT_W-1:0])));

    // R4: without tick or write the seconds hold
    a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count));

    // R8: every tick raises the tick flag
    a_r8_tick_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flags[1]);

    // R9: a clear without a coincident tick drops the tick flag
    a_r9_tick_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wdata[1] && !tick) |=> !flags[1]);

    // R7: the alarm flag rises only when seconds reach the alarm value
    a_r7_alarm_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> (count == $past(alarm)));

endmodule

bind rtc_trim_top rtc_trim_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .xtal_en (xtal_en),
    .tick    (div_tick),
    .cnt_wr  (cnt_wr),
    .st_wr   (st_wr),
    .wdata   (bus_wdata),
    .count   (count_q),
    .alarm   (alarm_q),
    .flags   (flag_q)
);

// File: tb/rtc_trim_top_bench.sv
`timescale 1ns/1ps
module rtc_trim_top_bench;

    localparam logic [4:0] A_ALARM = 5'h00;
    localparam logic [4:0] A_COUNT = 5'h04;
    localparam logic [4:0] A_TRIM  = 5'h08;
    localparam logic [4:0] A_STAT  = 5'h10;

    // Vector table: divisor C, trim D, expected gaps of periods 1..4 after a restart.
    localparam int NV = 4;
    localparam int VC [NV] = '{3, 3, 6, 2};
    localparam int VD [NV] = '{0, 3, 1, 1023};
    localparam int VGAP [NV][4] = '{'{4, 4, 4, 4},
                                    '{5, 5, 4, 4},
                                    '{7, 7, 7, 7},
                                    '{4, 4, 4, 4}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_en = 1'b0;
    logic [4:0]  bus_addr = A_COUNT;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_alarm;
    logic        irq_tick;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rtc_trim_top u_rtc_trim_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_en   (xtal_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_alarm (irq_alarm),
        .irq_tick  (irq_tick)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called just after a negedge: read combinationally, no clock edge passes.
    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = A_COUNT;
    endtask

    // Called at a negedge: drive one write, captured at the next posedge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = A_COUNT;
    endtask

    // Count negedges until the seconds value changes.
    task automatic wait_change(output int n);
        logic [31:0] p;
        logic [31:0] c;
        n = 0;
        rd(A_COUNT, p);
        do begin
            @(negedge clk);
            n++;
            rd(A_COUNT, c);
        end while (c == p);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int n;
        int m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_ALARM, d); chk("R1 alarm", d, 32'h0);
        rd(A_COUNT, d); chk("R1 count", d, 32'h0);
        rd(A_TRIM, d);  chk("R1 trim", d, 32'h0000_7FFF);
        rd(A_STAT, d);  chk("R1 status", d, 32'h0);
        chk("R1 irqs", {30'b0, irq_alarm, irq_tick}, 32'h0);

        // R11: unmapped offsets read zero and ignore writes
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h0C, d);   chk("R11 unmapped read", d, 32'h0);
        rd(A_TRIM, d);  chk("R11 trim untouched", d, 32'h0000_7FFF);
        rd(A_ALARM, d); chk("R11 alarm untouched", d, 32'h0);
        rd(A_STAT, d);  chk("R11 status untouched", d, 32'h0);

        xtal_en = 1'b1;

        // R2 R3: vector table of period lengths after a restart
        for (int v = 0; v < NV; v++) begin
            wr(A_TRIM, (32'(VD[v]) << 16) | 32'(VC[v]));
            rd(A_TRIM, d);
            chk("R11 trim field layout", d, (32'(VD[v]) << 16) | 32'(VC[v]));
            wait_change(n);
            wr(A_COUNT, 32'h0);
            wait_change(n);
            for (int j = 0; j < 4; j++) begin
                wait_change(n);
                chk($sformatf("R2 R3 vec%0d gap%0d", v, j), 32'(n), 32'(VGAP[v][j]));
            end
        end

        // R6: trim adopted only at the end of the running period (old period 4)
        wait_change(n);
        wr(A_TRIM, 32'd9);
        wait_change(m);
        chk("R6 current period kept", 32'(1 + m), 32'd4);
        wait_change(n);
        chk("R6 new period used", 32'(n), 32'd10);

        // R2: strobe held low for 30 cycles stretches the period by 30
        wait_change(n);
        repeat (2) @(negedge clk);
        xtal_en = 1'b0;
        rd(A_COUNT, d);
        repeat (30) @(negedge clk);
        begin
            logic [31:0] d2;
            rd(A_COUNT, d2);
            chk("R2 no advance without strobe", d2, d);
        end
        xtal_en = 1'b1;
        wait_change(m);
        chk("R2 gated period", 32'(2 + 30 + m), 32'd40);

        // R5: seconds write restarts the phase
        wait_change(n);
        repeat (3) @(negedge clk);
        wr(A_COUNT, 32'h1000);
        wait_change(m);
        chk("R5 restart period", 32'(1 + m), 32'd12);
        rd(A_COUNT, d); chk("R5 loaded then advanced", d, 32'h1001);

        // R5: write on the tick edge wins over the advance
        wait_change(n);
        repeat (9) @(negedge clk);
        wr(A_COUNT, 32'h55);
        rd(A_COUNT, d); chk("R5 write beats advance", d, 32'h55);

        // R4: wrap at the top of the range
        wr(A_COUNT, 32'hFFFF_FFFE);
        wait_change(n);
        rd(A_COUNT, d); chk("R4 step", d, 32'hFFFF_FFFF);
        wait_change(n);
        rd(A_COUNT, d); chk("R4 wrap", d, 32'h0);

        // R7 R8 R9 R10: alarm, flags and enables
        wr(A_ALARM, 32'h20);
        wr(A_COUNT, 32'h1E);
        wr(A_STAT, 32'h3);
        wait_change(n);
        rd(A_STAT, d); chk("R7 no alarm before match", d & 32'h1, 32'h0);
        wait_change(n);
        rd(A_STAT, d); chk("R7 R8 flags at match", d, 32'h3);
        chk("R10 alarm irq masked", {31'b0, irq_alarm}, 32'h0);
        wr(A_STAT, 32'h4);
        rd(A_STAT, d); chk("R9 zero leaves flags", d, 32'h7);
        chk("R10 alarm irq enabled", {30'b0, irq_alarm, irq_tick}, 32'h2);
        wr(A_STAT, 32'h5);
        rd(A_STAT, d); chk("R9 alarm cleared", d, 32'h6);
        chk("R10 alarm irq drops", {31'b0, irq_alarm}, 32'h0);

        // R9 R10: clear landing on the setting tick leaves both flags set
        wait_change(n);
        rd(A_COUNT, d);
        wr(A_ALARM, d + 32'h1);
        repeat (8) @(negedge clk);
        wr(A_STAT, 32'hF);
        rd(A_STAT, d); chk("R9 set beats clear", d, 32'hF);
        chk("R10 both irqs", {30'b0, irq_alarm, irq_tick}, 32'h3);
        wr(A_STAT, 32'hF);
        rd(A_STAT, d); chk("R9 later clear", d, 32'hC);
        chk("R10 irqs low", {30'b0, irq_alarm, irq_tick}, 32'h0);

        // R3: group numbering wraps after 1023 periods (C=0, D=1)
        wr(A_TRIM, 32'h0001_0000);
        wait_change(n);
        wr(A_COUNT, 32'h0);
        wait_change(n);
        rd(A_COUNT, d); chk("R3 first count", d, 32'h1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            rd(A_COUNT, d);
        end while (d != 32'd1024 && n < 3000);
        chk("R3 group wrap cycles", 32'(n), 32'd1024);

        finish_run();
    end

endmodule